// File: doc/BRIEF.md
# Gate-Driver Fault Supervisor with Timed Retry

This block watches the digital fault flags around an H-bridge gate driver. From them it decides which subsystems stay powered, and it drives one active-low fault line. The flags arrive already synchronized, and the analog comparators apply their hysteresis before the block sees them. Supply undervoltage and overtemperature shut down the bridge, the charge pump and the analog regulator. Charge-pump undervoltage shuts down only the bridge. Each of these three recovers as soon as its flag drops. Drain-source overcurrent on a driven FET, sense-pin overcurrent and a gate-feedback mismatch at the end of a drive window each start a timed retry instead. During the retry the bridge is held off for a fixed number of cycles. The bridge then tries again, and the cycle repeats while the fault persists. When several faults are active at once, all of their shutdowns apply, and the fault line stays low until the last one clears.

A run request moves the block through sleep and wake sequences. The power sequencer has four states: PW_SLEEP, PW_WAKE, PW_RUN and PW_ENTER. PW_SLEEP goes to PW_WAKE when the run request rises. PW_WAKE goes to PW_RUN after the wake delay, or back to PW_SLEEP if the request drops. PW_RUN goes to PW_ENTER when the request drops. PW_ENTER goes to PW_SLEEP after the sleep delay, or back to PW_RUN if the request returns. The retry machine has two states. RT_IDLE goes to RT_HOLD on a trip. RT_HOLD returns to RT_IDLE after the retry period, or at once when the block stops operating.

Top module: `gdrv_fault_sup`

## Requirements
- R1: After reset the block is asleep, with bridge_dis=1, cp_en=0, avdd_en=0 and fault_n=1.
- R2: Once run_req is sampled high while asleep, avdd_en is 1 from the next edge. The bridge stays disabled and cp_en stays 0 for WAKE_CYC+1 edges, and they come on at that edge.
- R3: Once run_req is sampled low while running, operation continues for SLEEP_CYC+1 edges, then all outputs take the R1 values. If run_req returns before then, the block stays running.
- R4: While uv_supply=1 (and the block is running), bridge_dis=1, cp_en=0, avdd_en=0 and fault_n=0 in the same cycle. All recover when the flag drops.
- R5: While uv_pump=1, bridge_dis=1 and fault_n=0, while cp_en and avdd_en stay 1.
- R6: While over_temp=1 the outputs are as in R4, and they recover when the flag drops.
- R7: A vds_hi bit whose fet_on bit is 1 trips on the DEGLITCH_CYC+1-th consecutive high sample. A shorter run of high samples does nothing. A flag on an undriven FET does nothing.
- R8: A trip holds bridge_dis=1 and fault_n=0 for exactly RETRY_CYC cycles, then releases both. If the fault persists, it trips again after a fresh deglitch.
- R9: Bits [N_FET/2-1:0] of vds_hi and fet_on are the high-side FETs, and their flags are ignored while hs_mon_off=1. Low-side flags are still monitored.
- R10: sense_oc goes through the same deglitch and retry as the drain-source flags.
- R11: Any change of gate_cmd opens a window of DRIVE_CYC cycles. If gate_fb differs from gate_cmd in the window's last cycle, the R8 retry starts. A mismatch that resolves earlier does nothing.
- R12: With several faults active, the union of their shutdowns applies, and fault_n stays 0 until every one has cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_req | input | 1 | 1 requests operation, 0 requests sleep |
| uv_supply | input | 1 | Supply undervoltage flag |
| uv_pump | input | 1 | Charge-pump undervoltage flag |
| over_temp | input | 1 | Overtemperature flag, hysteresis applied |
| hs_mon_off | input | 1 | Drive-strength setting that masks high-side drain-source monitoring |
| fet_on | input | N_FET | FETs currently driven (low half high-side) |
| vds_hi | input | N_FET | Drain-source over-threshold flags per FET |
| sense_oc | input | 1 | Sense-pin overcurrent flag |
| gate_cmd | input | N_FET | Commanded gate states |
| gate_fb | input | N_FET | Gate feedback above threshold |
| bridge_dis | output | 1 | 1 turns all bridge FETs off |
| cp_en | output | 1 | Charge-pump enable |
| avdd_en | output | 1 | Analog regulator enable |
| fault_n | output | 1 | Active-low fault indication |

## Verification
The level faults act combinationally, so their results are due in the same cycle as the flag. The bench samples them one clock after a change. A drain-source or sense trip appears DEGLITCH_CYC+1 edges after the flag rises, and it releases RETRY_CYC edges after that. A gate mismatch trips DRIVE_CYC+1 edges after the command change. The wake and sleep transitions land WAKE_CYC+1 and SLEEP_CYC+1 edges after run_req is sampled. The bench counts edges from each stimulus and checks one cycle before each due edge and on it. Every sample is taken just after a falling edge.

// File: rtl/gfs_pkg.sv
package gfs_pkg;
    typedef enum logic [1:0] {
        PW_SLEEP = 2'd0,
        PW_WAKE  = 2'd1,
        PW_RUN   = 2'd2,
        PW_ENTER = 2'd3
    } pw_state_t;

    typedef enum logic {
        RT_IDLE = 1'b0,
        RT_HOLD = 1'b1
    } rt_state_t;
endpackage

// File: rtl/gfs_power_seq.sv
module gfs_power_seq
    import gfs_pkg::*;
#(
    parameter int SLEEP_CYC = 200,
    parameter int WAKE_CYC  = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_req,
    output logic active,
    output logic waking,
    output logic powered
);
    localparam int MAXC = (SLEEP_CYC > WAKE_CYC) ? SLEEP_CYC : WAKE_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    pw_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PW_SLEEP: if (run_req) begin
                state_d = PW_WAKE;
                cnt_d   = '0;
            end
            PW_WAKE: begin
                if (!run_req) state_d = PW_SLEEP;
                else if (cnt_q == CW'(WAKE_CYC - 1)) state_d = PW_RUN;
                else cnt_d = cnt_q + 1'b1;
            end
            PW_RUN: if (!run_req) begin
                state_d = PW_ENTER;
                cnt_d   = '0;
            end
            PW_ENTER: begin
                if (run_req) state_d = PW_RUN;
                else if (cnt_q == CW'(SLEEP_CYC - 1)) state_d = PW_SLEEP;
                else cnt_d = cnt_q + 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PW_SLEEP;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        active  = (state_q == PW_RUN) || (state_q == PW_ENTER);
        waking  = (state_q == PW_WAKE);
        powered = (state_q != PW_SLEEP);
    end
endmodule

// File: rtl/gfs_ocp_filter.sv
module gfs_ocp_filter #(
    parameter int N_FET        = 4,
    parameter int DEGLITCH_CYC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [N_FET-1:0] fet_on,
    input  logic [N_FET-1:0] vds_hi,
    input  logic             hs_mon_off,
    input  logic             sense_oc,
    output logic             trip
);
    localparam int DW = $clog2(DEGLITCH_CYC + 1);
    localparam int HS = N_FET / 2;

    logic [N_FET-1:0] watch;
    logic [DW-1:0]    cnt_q;
    logic             hit;

    for (genvar i = 0; i < N_FET; i++) begin : g_mask
        if (i < HS) begin : g_hs
            assign watch[i] = vds_hi[i] & fet_on[i] & ~hs_mon_off;
        end else begin : g_ls
            assign watch[i] = vds_hi[i] & fet_on[i];
        end
    end

    assign hit  = (|watch) | sense_oc;
    assign trip = hit && !clr && (cnt_q == DW'(DEGLITCH_CYC));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else if (clr || !hit) cnt_q <= '0;
        else if (cnt_q != DW'(DEGLITCH_CYC)) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/gfs_pdf_watch.sv
module gfs_pdf_watch #(
    parameter int N_FET     = 4,
    parameter int DRIVE_CYC = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [N_FET-1:0] gate_cmd,
    input  logic [N_FET-1:0] gate_fb,
    output logic             trip
);
    localparam int WW = $clog2(DRIVE_CYC + 1);

    logic [N_FET-1:0] cmd_q;
    logic [WW-1:0]    win_q;

    assign trip = !clr && (win_q == WW'(1)) && (gate_fb != gate_cmd);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
            win_q <= '0;
        end else begin
            cmd_q <= gate_cmd;
            if (clr) win_q <= '0;
            else if (gate_cmd != cmd_q) win_q <= WW'(DRIVE_CYC);
            else if (win_q != '0) win_q <= win_q - 1'b1;
        end
    end
endmodule

// File: rtl/gfs_retry.sv
module gfs_retry
    import gfs_pkg::*;
#(
    parameter int RETRY_CYC = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic trip,
    output logic hold
);
    localparam int RW = $clog2(RETRY_CYC + 1);

    rt_state_t state_q, state_d;
    logic [RW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            RT_IDLE: if (en && trip) begin
                state_d = RT_HOLD;
                cnt_d   = '0;
            end
            RT_HOLD: begin
                if (!en || cnt_q == RW'(RETRY_CYC - 1)) state_d = RT_IDLE;
                else cnt_d = cnt_q + 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RT_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb hold = (state_q == RT_HOLD);
endmodule

// File: rtl/gdrv_fault_sup.sv
module gdrv_fault_sup #(
    parameter int N_FET        = 4,
    parameter int DEGLITCH_CYC = 16,
    parameter int RETRY_CYC    = 4000,
    parameter int DRIVE_CYC    = 40,
    parameter int SLEEP_CYC    = 200,
    parameter int WAKE_CYC     = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_req,
    input  logic             uv_supply,
    input  logic             uv_pump,
    input  logic             over_temp,
    input  logic             hs_mon_off,
    input  logic [N_FET-1:0] fet_on,
    input  logic [N_FET-1:0] vds_hi,
    input  logic             sense_oc,
    input  logic [N_FET-1:0] gate_cmd,
    input  logic [N_FET-1:0] gate_fb,
    output logic             bridge_dis,
    output logic             cp_en,
    output logic             avdd_en,
    output logic             fault_n
);
    logic pw_active, pw_waking, pw_powered;
    logic rt_hold, ocp_trip, pdf_trip, lvl_fault, pwr_cut;

    gfs_power_seq #(.SLEEP_CYC(SLEEP_CYC), .WAKE_CYC(WAKE_CYC)) u_pwr (
        .clk(clk), .rst_n(rst_n), .run_req(run_req),
        .active(pw_active), .waking(pw_waking), .powered(pw_powered)
    );

    gfs_ocp_filter #(.N_FET(N_FET), .DEGLITCH_CYC(DEGLITCH_CYC)) u_ocp (
        .clk(clk), .rst_n(rst_n), .clr(bridge_dis), .fet_on(fet_on),
        .vds_hi(vds_hi), .hs_mon_off(hs_mon_off), .sense_oc(sense_oc),
        .trip(ocp_trip)
    );

    gfs_pdf_watch #(.N_FET(N_FET), .DRIVE_CYC(DRIVE_CYC)) u_pdf (
        .clk(clk), .rst_n(rst_n), .clr(bridge_dis), .gate_cmd(gate_cmd),
        .gate_fb(gate_fb), .trip(pdf_trip)
    );

    gfs_retry #(.RETRY_CYC(RETRY_CYC)) u_rty (
        .clk(clk), .rst_n(rst_n), .en(pw_active),
        .trip(ocp_trip | pdf_trip), .hold(rt_hold)
    );

    always_comb begin
        lvl_fault  = uv_supply | uv_pump | over_temp;
        pwr_cut    = uv_supply | over_temp;
        bridge_dis = !pw_active || lvl_fault || rt_hold;
        cp_en      = pw_active && !pwr_cut;
        avdd_en    = pw_powered && !pwr_cut;
        fault_n    = !(pw_active && (lvl_fault || rt_hold));
    end
endmodule

// File: rtl/gdrv_fault_sup_chk.sv
module gdrv_fault_sup_chk (
    input logic clk,
    input logic rst_n,
    input logic uv_supply,
    input logic uv_pump,
    input logic over_temp,
    input logic bridge_dis,
    input logic cp_en,
    input logic avdd_en,
    input logic fault_n,
    input logic pw_active,
    input logic pw_waking,
    input logic rt_hold
);
    // R4
    uvs_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uv_supply |-> bridge_dis && !cp_en && !avdd_en);

    // R6
    hot_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        over_temp |-> bridge_dis && !cp_en && !avdd_en);

    // R5
    pump_uv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_pump && pw_active) |-> bridge_dis && !fault_n);

    // R2
    wake_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pw_waking |-> bridge_dis && !cp_en && fault_n);

    // R8
    retry_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rt_hold) |=> (rt_hold || !pw_active));

    // R12
    fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n |-> bridge_dis);

    // R3
    rail_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !avdd_en |-> !cp_en);
endmodule

bind gdrv_fault_sup gdrv_fault_sup_chk u_chk (
    .clk(clk), .rst_n(rst_n), .uv_supply(uv_supply), .uv_pump(uv_pump),
    .over_temp(over_temp), .bridge_dis(bridge_dis), .cp_en(cp_en),
    .avdd_en(avdd_en), .fault_n(fault_n), .pw_active(pw_active),
    .pw_waking(pw_waking), .rt_hold(rt_hold)
);

// File: tb/sim_gdrv_fault_sup.sv
`timescale 1ns/1ps
module sim_gdrv_fault_sup;
    localparam int NF = 4;
    localparam int DG = 3;
    localparam int RT = 8;
    localparam int DR = 4;
    localparam int SL = 4;
    localparam int WK = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_req = 1'b0, uv_supply = 1'b0, uv_pump = 1'b0, over_temp = 1'b0;
    logic hs_mon_off = 1'b0, sense_oc = 1'b0;
    logic [NF-1:0] fet_on = '0, vds_hi = '0, gate_cmd = '0, gate_fb = '0;
    logic bridge_dis, cp_en, avdd_en, fault_n;

    always #2.5 clk = ~clk;

    gdrv_fault_sup #(.N_FET(NF), .DEGLITCH_CYC(DG), .RETRY_CYC(RT),
        .DRIVE_CYC(DR), .SLEEP_CYC(SL), .WAKE_CYC(WK)) u0 (
        .clk(clk), .rst_n(rst_n), .run_req(run_req), .uv_supply(uv_supply),
        .uv_pump(uv_pump), .over_temp(over_temp), .hs_mon_off(hs_mon_off),
        .fet_on(fet_on), .vds_hi(vds_hi), .sense_oc(sense_oc),
        .gate_cmd(gate_cmd), .gate_fb(gate_fb), .bridge_dis(bridge_dis),
        .cp_en(cp_en), .avdd_en(avdd_en), .fault_n(fault_n)
    );

    typedef struct {
        string      tag;
        logic [3:0] exp;
    } exp_t;

    exp_t sbq[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    // Result order: {bridge_dis, cp_en, avdd_en, fault_n}
    localparam logic [3:0] ASLEEP = 4'b1001;
    localparam logic [3:0] RUN    = 4'b0111;
    localparam logic [3:0] WAKING = 4'b1011;
    localparam logic [3:0] TRIP   = 4'b1110;
    localparam logic [3:0] CUT    = 4'b1000;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic expect_out(input string tag, input logic [3:0] e);
        exp_t it;
        it.tag = tag;
        it.exp = e;
        sbq.push_back(it);
        wait (sbq.size() == 0);
    endtask

    initial begin : monitor
        forever begin
            exp_t it;
            logic [3:0] got;
            wait (sbq.size() != 0);
            it  = sbq.pop_front();
            got = {bridge_dis, cp_en, avdd_en, fault_n};
            n_cmp++;
            if (got !== it.exp) begin
                n_bad++;
                $display("FAIL %s: got %b expected %b at %0t", it.tag, got, it.exp, $time);
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : driver
        step(3);
        rst_n = 1'b1;
        step(1);
        expect_out("R1 reset sleep", ASLEEP);
        step(2);
        expect_out("R1 stays asleep", ASLEEP);

        // R2 wake delay
        run_req = 1'b1;
        step(1);
        expect_out("R2 regulator up during wake", WAKING);
        step(WK - 1);
        expect_out("R2 bridge still held at wake end-1", WAKING);
        step(1);
        expect_out("R2 running after wake delay", RUN);

        // R3 sleep cancel, then full sleep
        run_req = 1'b0;
        step(2);
        run_req = 1'b1;
        step(SL + 2);
        expect_out("R3 cancelled sleep keeps running", RUN);
        run_req = 1'b0;
        step(SL);
        expect_out("R3 running through sleep delay", RUN);
        step(1);
        expect_out("R3 asleep after delay", ASLEEP);
        run_req = 1'b1;
        step(WK + 1);
        expect_out("R2 rewake", RUN);

        fet_on = 4'b0101;
        gate_cmd = 4'b0101;
        gate_fb = 4'b0101;
        step(6);
        expect_out("R11 matched feedback no trip", RUN);

        // R7 deglitch and R8 retry
        vds_hi = 4'b0001;
        step(DG);
        expect_out("R7 no trip before deglitch", RUN);
        step(1);
        expect_out("R7 trip after deglitch", TRIP);
        step(RT - 1);
        expect_out("R8 hold until retry end", TRIP);
        step(1);
        expect_out("R8 release after retry", RUN);
        step(DG);
        expect_out("R8 persisting fault deglitching", RUN);
        step(1);
        expect_out("R8 persisting fault retrips", TRIP);
        vds_hi = 4'b0000;
        step(RT);
        expect_out("R8 clean release", RUN);

        vds_hi = 4'b0001;
        step(DG);
        vds_hi = 4'b0000;
        step(4);
        expect_out("R7 short pulse ignored", RUN);
        vds_hi = 4'b1000;
        step(8);
        expect_out("R7 undriven FET ignored", RUN);
        vds_hi = 4'b0000;

        // R9 high-side mask
        hs_mon_off = 1'b1;
        vds_hi = 4'b0001;
        step(8);
        expect_out("R9 masked high side", RUN);
        vds_hi = 4'b0100;
        step(DG);
        expect_out("R9 low side deglitching", RUN);
        step(1);
        expect_out("R9 low side trips", TRIP);
        vds_hi = 4'b0000;
        hs_mon_off = 1'b0;
        step(RT);
        expect_out("R9 release", RUN);

        // R10 sense overcurrent
        sense_oc = 1'b1;
        step(DG + 1);
        expect_out("R10 sense trip", TRIP);
        sense_oc = 1'b0;
        step(RT);
        expect_out("R10 release", RUN);

        // R11 gate feedback mismatch
        gate_cmd = 4'b0110;
        step(DR);
        expect_out("R11 within window", RUN);
        step(1);
        expect_out("R11 mismatch trip", TRIP);
        gate_fb = 4'b0110;
        step(RT);
        expect_out("R11 release", RUN);
        gate_cmd = 4'b1001;
        step(2);
        gate_fb = 4'b1001;
        step(6);
        expect_out("R11 late-settling feedback ok", RUN);

        // R4 R5 R6 level faults
        uv_supply = 1'b1;
        step(1);
        expect_out("R4 supply undervoltage", CUT);
        uv_supply = 1'b0;
        step(1);
        expect_out("R4 recovery", RUN);
        uv_pump = 1'b1;
        step(1);
        expect_out("R5 pump undervoltage", TRIP);
        uv_pump = 1'b0;
        step(1);
        expect_out("R5 recovery", RUN);
        over_temp = 1'b1;
        step(1);
        expect_out("R6 overtemperature", CUT);
        over_temp = 1'b0;
        step(1);
        expect_out("R6 recovery", RUN);

        // R12 union
        uv_pump = 1'b1;
        over_temp = 1'b1;
        step(1);
        expect_out("R12 union of cuts", CUT);
        over_temp = 1'b0;
        step(1);
        expect_out("R12 pump fault remains", TRIP);
        uv_pump = 1'b0;
        step(1);
        expect_out("R12 all clear", RUN);
        vds_hi = 4'b0001;
        step(DG + 1);
        expect_out("R12 trip before level fault", TRIP);
        vds_hi = 4'b0000;
        uv_pump = 1'b1;
        step(RT);
        expect_out("R12 level fault outlasts retry", TRIP);
        uv_pump = 1'b0;
        step(1);
        expect_out("R12 final clear", RUN);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule